// File: doc/BRIEF.md
# Future File With In-Order Commit

This block keeps two copies of a small register file so that exceptions stay precise even though functional units finish out of program order. Each instruction is given a sequence tag at issue. When a unit reports a result, the value goes at once into the speculative "future" copy, which serves all operand reads. A circular completion buffer, indexed by tag, holds each result until every older instruction has completed. Results then move into the architectural copy strictly in issue order, at most one per cycle.

A completion can carry an exception flag. When that entry reaches the head of the buffer, the block raises an exception pulse carrying the faulting tag. It then discards the faulting entry and every younger one, and overwrites the future copy with the architectural copy. After that, reads return exactly the register state produced by the instructions older than the fault.

Control is a two-state machine. In state RUN, issue, completion and retirement are enabled. The transition RUN→TRAP is taken when the head entry has completed with its exception flag set. In state TRAP, which lasts one cycle, issue and completion are blocked and recovery is performed. The transition TRAP→RUN is unconditional.

Top module: `future_file`

## Requirements
- R1: After reset both register copies read as zero, `iss_ready` is 1, `iss_tag` is 0 and `exc_valid` is 0.
- R2: Tags are handed out in sequence. `iss_tag` shows the tag for the next instruction, and every accepted issue (`iss_valid` and `iss_ready` both high) advances it by one, modulo DEPTH.
- R3: When DEPTH instructions are outstanding, `iss_ready` is 0, and an issue request in that state changes neither `iss_tag` nor any other state.
- R4: A completion without exception for an outstanding, not yet completed tag, whose instruction is the youngest issued writer of its destination, is returned by the read ports from the cycle after the clock edge.
- R5: If such a completion and a read address name the same register in the same cycle, that read port returns the completion value combinationally in that cycle.
- R6: A completion whose instruction has a younger issued writer of the same destination leaves the future copy unchanged (no write-after-write reversal).
- R7: The head entry retires into the architectural copy once it has completed, at most one entry per cycle and only in tag order. Each retirement frees one buffer slot.
- R8: When the head entry has completed with the exception flag, `exc_valid` is 1 for exactly the following cycle, with `exc_tag` equal to that entry's tag. In that cycle `iss_ready` is 0. After it, reads return the architectural state made of the retired results of all older instructions, all younger entries are gone, and `iss_tag` equals the faulting tag.
- R9: A completion whose tag is not outstanding, or is already completed, or that arrives in the TRAP cycle, has no effect.
- R10: A completion with the exception flag set writes nothing to the future copy. Neither the bypass nor later reads show its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Request to allocate a tag for a new instruction |
| iss_dest | input | $clog2(NREG) | Destination register of the issuing instruction |
| iss_ready | output | 1 | Allocation possible this cycle |
| iss_tag | output | $clog2(DEPTH) | Tag given to the next accepted issue |
| cmp_valid | input | 1 | A functional unit reports a result |
| cmp_tag | input | $clog2(DEPTH) | Tag of the completing instruction |
| cmp_value | input | DW | Result value |
| cmp_exc | input | 1 | The result raised an arithmetic exception |
| rd_addr | input | NRD*$clog2(NREG) | Read addresses, port 0 in the low bits |
| rd_data | output | NRD*DW | Read data from the future copy, port 0 in the low bits |
| exc_valid | output | 1 | Exception taken this cycle (TRAP state) |
| exc_tag | output | $clog2(DEPTH) | Tag of the faulting instruction, meaningful while exc_valid is 1 |

## Verification
The hardest situation to reach is an exception that surfaces while older results are still retiring and younger ones have already overwritten registers in the future copy. Recovery is visible only if the future copy differs from the architectural one at the moment of the fault. The stimulus therefore issues a write to one register, then the faulting instruction, then a younger write to another register. It completes the younger instruction first and the faulting one last, and reads both registers after the exception pulse. A long random phase then mixes out-of-order completions, stale tags, double completions and sporadic exception flags against a queue-based reference model.

// File: rtl/ff_pkg.sv
package ff_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_TRAP = 1'b1
    } ff_state_e;
endpackage

// File: rtl/ff_ctrl.sv
module ff_ctrl
    import ff_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic head_fault,
    output logic run,
    output logic trap
);
    ff_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (head_fault) state_d = ST_TRAP;
            ST_TRAP: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        run  = 1'b0;
        trap = 1'b0;
        unique case (state_q)
            ST_RUN:  run  = 1'b1;
            ST_TRAP: trap = 1'b1;
            default: run  = 1'b1;
        endcase
    end
endmodule

// File: rtl/ff_cbuf.sv
module ff_cbuf #(
    parameter int DEPTH = 8,
    parameter int NREG  = 8,
    parameter int DW    = 16,
    localparam int TW   = $clog2(DEPTH),
    localparam int RW   = $clog2(NREG),
    localparam int CW   = TW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          flush,
    input  logic          iss_valid,
    input  logic [RW-1:0] iss_dest,
    output logic          iss_ready,
    output logic [TW-1:0] iss_tag,
    output logic [CW-1:0] occ,
    input  logic          cmp_valid,
    input  logic [TW-1:0] cmp_tag,
    input  logic [DW-1:0] cmp_value,
    input  logic          cmp_exc,
    output logic          fwr_en,
    output logic [RW-1:0] fwr_addr,
    output logic [DW-1:0] fwr_data,
    output logic          ret_en,
    output logic [RW-1:0] ret_addr,
    output logic [DW-1:0] ret_data,
    output logic          head_fault,
    output logic [TW-1:0] head_tag
);
    logic [DEPTH-1:0] busy, done, fault;
    logic [RW-1:0]    dest  [DEPTH];
    logic [DW-1:0]    val   [DEPTH];
    logic [TW-1:0]    owner [NREG];
    logic [TW-1:0]    head, tail;
    logic             iss_fire, cmp_ok, head_done;

    assign iss_ready = run && (occ != CW'(DEPTH));
    assign iss_fire  = iss_valid && iss_ready;
    assign iss_tag   = tail;
    assign head_tag  = head;

    assign cmp_ok    = run && cmp_valid && busy[cmp_tag] && !done[cmp_tag];
    assign fwr_addr  = dest[cmp_tag];
    assign fwr_data  = cmp_value;
    assign fwr_en    = cmp_ok && !cmp_exc && (owner[dest[cmp_tag]] == cmp_tag);

    assign head_done  = busy[head] && done[head];
    assign head_fault = run && head_done && fault[head];
    assign ret_en     = run && head_done && !fault[head];
    assign ret_addr   = dest[head];
    assign ret_data   = val[head];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= '0;
            done  <= '0;
            fault <= '0;
            head  <= '0;
            tail  <= '0;
            occ   <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                dest[i] <= '0;
                val[i]  <= '0;
            end
            for (int r = 0; r < NREG; r++) owner[r] <= '0;
        end else if (flush) begin
            busy <= '0;
            done <= '0;
            tail <= head;
            occ  <= '0;
        end else begin
            if (cmp_ok) begin
                done[cmp_tag]  <= 1'b1;
                fault[cmp_tag] <= cmp_exc;
                val[cmp_tag]   <= cmp_value;
            end
            if (iss_fire) begin
                busy[tail]      <= 1'b1;
                done[tail]      <= 1'b0;
                fault[tail]     <= 1'b0;
                dest[tail]      <= iss_dest;
                owner[iss_dest] <= tail;
                tail            <= tail + 1'b1;
            end
            if (ret_en) begin
                busy[head] <= 1'b0;
                head       <= head + 1'b1;
            end
            occ <= occ + CW'(iss_fire) - CW'(ret_en);
        end
    end
endmodule

// File: rtl/ff_regbank.sv
module ff_regbank #(
    parameter int NREG = 8,
    parameter int DW   = 16,
    parameter int NRD  = 2,
    localparam int RW  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwr_en,
    input  logic [RW-1:0]     fwr_addr,
    input  logic [DW-1:0]     fwr_data,
    input  logic              awr_en,
    input  logic [RW-1:0]     awr_addr,
    input  logic [DW-1:0]     awr_data,
    input  logic              restore,
    input  logic [NRD*RW-1:0] rd_addr,
    output logic [NRD*DW-1:0] rd_data
);
    logic [DW-1:0] fut  [NREG];
    logic [DW-1:0] arch [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin
                fut[r]  <= '0;
                arch[r] <= '0;
            end
        end else begin
            if (restore) begin
                for (int r = 0; r < NREG; r++) fut[r] <= arch[r];
            end else if (fwr_en) begin
                fut[fwr_addr] <= fwr_data;
            end
            if (awr_en) arch[awr_addr] <= awr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [RW-1:0] a;
        assign a = rd_addr[p*RW +: RW];
        always_comb begin
            if (fwr_en && !restore && (fwr_addr == a))
                rd_data[p*DW +: DW] = fwr_data;
            else
                rd_data[p*DW +: DW] = fut[a];
        end
    end
endmodule

// File: rtl/future_file.sv
module future_file #(
    parameter int DW    = 16,
    parameter int NREG  = 8,
    parameter int DEPTH = 8,
    parameter int NRD   = 2,
    localparam int RW   = $clog2(NREG),
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = TW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [RW-1:0]     iss_dest,
    output logic              iss_ready,
    output logic [TW-1:0]     iss_tag,
    input  logic              cmp_valid,
    input  logic [TW-1:0]     cmp_tag,
    input  logic [DW-1:0]     cmp_value,
    input  logic              cmp_exc,
    input  logic [NRD*RW-1:0] rd_addr,
    output logic [NRD*DW-1:0] rd_data,
    output logic              exc_valid,
    output logic [TW-1:0]     exc_tag
);
    logic          run, trap, head_fault;
    logic          fwr_en, ret_en;
    logic [RW-1:0] fwr_addr, ret_addr;
    logic [DW-1:0] fwr_data, ret_data;
    logic [CW-1:0] occ;

    ff_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_fault (head_fault),
        .run        (run),
        .trap       (trap)
    );

    ff_cbuf #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW)) u_cbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .flush      (trap),
        .iss_valid  (iss_valid),
        .iss_dest   (iss_dest),
        .iss_ready  (iss_ready),
        .iss_tag    (iss_tag),
        .occ        (occ),
        .cmp_valid  (cmp_valid),
        .cmp_tag    (cmp_tag),
        .cmp_value  (cmp_value),
        .cmp_exc    (cmp_exc),
        .fwr_en     (fwr_en),
        .fwr_addr   (fwr_addr),
        .fwr_data   (fwr_data),
        .ret_en     (ret_en),
        .ret_addr   (ret_addr),
        .ret_data   (ret_data),
        .head_fault (head_fault),
        .head_tag   (exc_tag)
    );

    ff_regbank #(.NREG(NREG), .DW(DW), .NRD(NRD)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .fwr_en   (fwr_en),
        .fwr_addr (fwr_addr),
        .fwr_data (fwr_data),
        .awr_en   (ret_en),
        .awr_addr (ret_addr),
        .awr_data (ret_data),
        .restore  (trap),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    assign exc_valid = trap;
endmodule

// File: rtl/ff_checks.sv
module ff_checks #(
    parameter int DEPTH = 8,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = TW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          iss_valid,
    input logic          iss_ready,
    input logic [TW-1:0] iss_tag,
    input logic          exc_valid,
    input logic [TW-1:0] exc_tag,
    input logic [CW-1:0] occ
);
    a_r2_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> (iss_tag == TW'($past(iss_tag) + 1'b1)));

    a_r3_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(DEPTH)) |-> !iss_ready);

    a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_ready && !exc_valid) |=> $stable(iss_tag));

    a_r7_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> !exc_valid);

    a_r8_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !iss_ready);

    a_r8_tag_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (iss_tag == $past(exc_tag)) && (occ == '0));
endmodule

bind future_file ff_checks #(.DEPTH(DEPTH)) u_ff_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_tag   (iss_tag),
    .exc_valid (exc_valid),
    .exc_tag   (exc_tag),
    .occ       (occ)
);

// File: tb/future_file_test.sv
`timescale 1ns/1ps
module future_file_test;
    localparam int DW = 16, NREG = 8, DEPTH = 8, NRD = 2;
    localparam int RW = $clog2(NREG), TW = $clog2(DEPTH);

    logic              clk = 1'b0, rst_n = 1'b0;
    logic              iss_valid = 1'b0, cmp_valid = 1'b0, cmp_exc = 1'b0;
    logic [RW-1:0]     iss_dest = '0;
    logic [TW-1:0]     cmp_tag = '0;
    logic [DW-1:0]     cmp_value = '0;
    logic [NRD*RW-1:0] rd_addr = '0;
    logic              iss_ready, exc_valid;
    logic [TW-1:0]     iss_tag, exc_tag;
    logic [NRD*DW-1:0] rd_data;

    future_file #(.DW(DW), .NREG(NREG), .DEPTH(DEPTH), .NRD(NRD)) uut (.*);

    always #10 clk = ~clk;

    typedef struct { int tag; int dest; bit done; bit exc; int val; } ent_t;
    ent_t q[$];
    int fut[NREG], arch[NREG];
    bit m_trap;
    int m_trap_tag, m_next;
    int n_chk = 0, n_bad = 0;
    logic [DW-1:0] obs_a, obs_b;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int find(int t);
        foreach (q[i]) if (q[i].tag == t && !q[i].done) return i;
        return -1;
    endfunction

    function automatic bit newest(int idx);
        for (int j = idx + 1; j < q.size(); j++) if (q[j].dest == q[idx].dest) return 0;
        return 1;
    endfunction

    function automatic int exp_rd(int a);
        int idx;
        idx = find(int'(cmp_tag));
        if (!m_trap && cmp_valid && idx >= 0 && !cmp_exc && newest(idx) && q[idx].dest == a)
            return int'(cmp_value);
        return fut[a];
    endfunction

    task automatic model_edge();
        if (m_trap) begin
            for (int r = 0; r < NREG; r++) fut[r] = arch[r];
            q.delete();
            m_next = m_trap_tag;
            m_trap = 0;
        end else begin
            bit flt, ret;
            int idx;
            flt = q.size() > 0 && q[0].done && q[0].exc;
            ret = q.size() > 0 && q[0].done && !q[0].exc;
            idx = find(int'(cmp_tag));
            if (cmp_valid && idx >= 0) begin
                if (!cmp_exc && newest(idx)) fut[q[idx].dest] = int'(cmp_value);
                q[idx].done = 1; q[idx].exc = cmp_exc; q[idx].val = int'(cmp_value);
            end
            if (iss_valid && q.size() < DEPTH) begin
                ent_t e;
                e.tag = m_next; e.dest = int'(iss_dest); e.done = 0; e.exc = 0; e.val = 0;
                q.push_back(e);
                m_next = (m_next + 1) % DEPTH;
            end
            if (ret) begin
                arch[q[0].dest] = q[0].val;
                void'(q.pop_front());
            end
            if (flt) begin
                m_trap = 1;
                m_trap_tag = q[0].tag;
            end
        end
    endtask

    // one cycle: drive, compare with the model, then let the model take the edge
    task automatic cyc(string lab, bit iv, int idest, bit cv, int ctag, int cval, bit cx,
                       int ra, int rb);
        @(negedge clk);
        iss_valid = iv; iss_dest = RW'(idest);
        cmp_valid = cv; cmp_tag = TW'(ctag); cmp_value = DW'(cval); cmp_exc = cx;
        rd_addr = {RW'(rb), RW'(ra)};
        #2;
        obs_a = rd_data[DW-1:0];
        obs_b = rd_data[2*DW-1:DW];
        check(lab != "" ? lab : "R3", iss_ready, (!m_trap && q.size() < DEPTH));
        check(lab != "" ? lab : "R2", iss_tag, m_next);
        check(lab != "" ? lab : "R8", exc_valid, m_trap);
        if (m_trap) check(lab != "" ? lab : "R8", exc_tag, m_trap_tag);
        check(lab != "" ? lab : "R4", obs_a, exp_rd(ra));
        check(lab != "" ? lab : "R4", obs_b, exp_rd(rb));
        @(posedge clk);
        model_edge();
    endtask

    task automatic idle(string lab, int n, int ra, int rb);
        for (int i = 0; i < n; i++) cyc(lab, 0, 0, 0, 0, 0, 0, ra, rb);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: run did not finish (all requirements)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int tx, tf, ty, ta, tb;
        for (int r = 0; r < NREG; r++) begin fut[r] = 0; arch[r] = 0; end
        m_trap = 0; m_next = 0; m_trap_tag = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        cyc("R1", 0, 0, 0, 0, 0, 0, 3, 5);
        check("R1", obs_a, 0);
        check("R1", iss_ready, 1);
        check("R1", iss_tag, 0);

        // R2: fill the buffer, one instruction per register
        for (int i = 0; i < DEPTH; i++) cyc("R2", 1, i, 0, 0, 0, 0, 0, 1);
        // R3: full, request ignored
        cyc("R3", 1, 6, 0, 0, 0, 0, 0, 1);
        check("R3", iss_ready, 0);
        check("R3", iss_tag, 0);

        // R5 / R4: complete in reverse order, read same-cycle and previous register
        for (int t = DEPTH - 1; t >= 0; t--) begin
            cyc("R5", 0, 0, 1, t, 100 + t, 0, t, (t + 1) % NREG);
            check("R5", obs_a, 100 + t);
        end
        // R7: in-order retirement frees slots
        idle("R7", DEPTH + 2, 2, 6);
        check("R7", iss_ready, 1);
        check("R4", obs_b, 106);

        // R6: two writers of register 2, younger finishes first
        ta = m_next; cyc("R6", 1, 2, 0, 0, 0, 0, 2, 2);
        tb = m_next; cyc("R6", 1, 2, 0, 0, 0, 0, 2, 2);
        cyc("R6", 0, 0, 1, tb, 'h55, 0, 2, 0);
        cyc("R6", 0, 0, 1, ta, 'h33, 0, 2, 0);
        check("R6", obs_a, 'h55);
        idle("R6", 3, 2, 0);
        check("R6", obs_a, 'h55);

        // R8 / R10: fault with an older and a younger result around it
        tx = m_next; cyc("R8", 1, 1, 0, 0, 0, 0, 1, 5);
        tf = m_next; cyc("R8", 1, 4, 0, 0, 0, 0, 1, 5);
        ty = m_next; cyc("R8", 1, 5, 0, 0, 0, 0, 1, 5);
        cyc("R8", 0, 0, 1, ty, 'h77, 0, 5, 1);
        check("R8", obs_a, 'h77);
        cyc("R8", 0, 0, 1, tx, 'h11, 0, 1, 5);
        cyc("R10", 0, 0, 1, tf, 'h99, 1, 4, 5);
        check("R10", obs_a, 104);
        idle("R8", 4, 5, 1);
        check("R8", obs_a, 105);
        check("R8", obs_b, 'h11);
        check("R10", obs_a == 'h99 ? 1 : 0, 0);
        check("R8", iss_tag, tf);

        // R9: stale tag and double completion are ignored
        ta = m_next; cyc("R9", 1, 3, 0, 0, 0, 0, 3, 0);
        cyc("R9", 0, 0, 1, (ta + 3) % DEPTH, 'hEEEE, 0, 3, 0);
        cyc("R9", 0, 0, 1, ta, 'h1234, 0, 3, 0);
        cyc("R9", 0, 0, 1, ta, 'hEEEE, 0, 3, 0);
        check("R9", obs_a, 'h1234);
        idle("R9", 3, 3, 0);
        check("R9", obs_a, 'h1234);

        // random mix against the model
        for (int c = 0; c < 4000; c++) begin
            bit iv, cv, cx;
            int ct;
            iv = ($urandom_range(9) < 6);
            cv = ($urandom_range(9) < 6);
            cx = ($urandom_range(19) == 0);
            ct = $urandom_range(DEPTH - 1);
            if (cv && q.size() > 0 && $urandom_range(7) != 0) begin
                int k;
                k = $urandom_range(q.size() - 1);
                ct = q[k].tag;
            end
            cyc("", iv, $urandom_range(NREG - 1), cv, ct, $urandom_range(16'hFFFF), cx,
                $urandom_range(NREG - 1), $urandom_range(NREG - 1));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule